// File: doc/BRIEF.md
# Card Command Issue and Response Capture Unit

This unit sits between a register port driven by software and a card-side request/response channel. Software loads a 32-bit argument and then writes a command word that holds a 6-bit command index, a response-expected flag, a long-response flag, two mode flags and a start bit. A start with both mode flags clear opens one transaction on the card channel. The request holds the index and the argument, which are frozen at issue time, and it stays asserted until the card answers or a fixed cycle budget runs out.

The card answers with a byte count, an error flag and up to sixteen bytes. The unit checks the count against the kind of response that was asked for. It packs a valid answer into four 32-bit response words and raises a sticky status bit for the result: command sent, response received or timeout. The start bit then clears itself. One cycle after every completion, a single-cycle pulse tells a neighbouring data mover that it may run.

Top module: `sdcmd_unit`

## Requirements
- R1: After reset, every readable register (argument at address 0, command at 1, status at 2, clear at 3, response words 0..3 at addresses 4..7) reads zero, and `card_req_valid` and `data_kick` are low.
- R2: A write to the command register (bit 10 start, bits 5:0 index) with start set and bits 8 and 9 clear, while no command is outstanding, raises `card_req_valid` in the next cycle. The request carries the written index and the argument register's value, status bit 11 reads 1 and command bit 10 reads 1 until completion.
- R3: When command bit 6 (response expected) is clear, any card answer without the error flag sets status bit 7 and leaves the response words unchanged.
- R4: When bit 6 is set, an answer with a count of 0, a count of 4 with bit 7 (long) set, or any count other than 4 or 16 sets status bit 2 and leaves the response words unchanged.
- R5: With bit 6 set, bit 7 clear and a count of 4, word 0 takes bytes 0..3 of `card_rsp_data` big-endian (byte i lies at bits 127-8i down to 120-8i), words 1..3 become zero, and status bit 6 is set.
- R6: With bit 6 set and a count of 16 (whatever bit 7 holds), word k takes bytes 4k..4k+3 big-endian, bit 0 of word 3 is forced to zero, and status bit 6 is set.
- R7: When a command completes, whatever the result, command bit 10 reads 0, status bit 11 reads 0 and `card_req_valid` is low from the next cycle.
- R8: If no answer arrives within TIMEOUT_CYCLES cycles of the request rising, status bit 2 is set and the response words are unchanged. An answer in the last cycle of that window is taken as the answer.
- R9: An answer with `card_rsp_err` high counts as a timeout (status bit 2), whatever the count.
- R10: While a command is outstanding, writes to the command register are ignored: the value read back and the request stay as they were.
- R11: A start written with bit 8 or bit 9 set issues nothing. The word is stored with bit 10 cleared, and no request or status change follows.
- R12: `data_kick` is high for exactly the one cycle after each completion and low otherwise.
- R13: A write to the clear register (address 3) clears each of status bits 2, 6 and 7 whose bit in the written word is 1, and leaves the others as they were. A bit that a completion sets in the same cycle stays set.
- R14: A card answer while no command is outstanding changes no status bit or response word and causes no `data_kick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| card_req_valid | output | 1 | Command outstanding on the card channel |
| card_req_index | output | 6 | Command index of the outstanding request |
| card_req_arg | output | 32 | Argument of the outstanding request |
| card_rsp_valid | input | 1 | Card answer strobe |
| card_rsp_err | input | 1 | Card reports failure |
| card_rsp_len | input | 5 | Answer length in bytes |
| card_rsp_data | input | 128 | Answer bytes, byte 0 in the top eight bits |
| data_kick | output | 1 | One-cycle pulse after each completion |

## Verification
Two pairs of events can land on the same edge. The first is a card answer arriving in the last cycle of the timeout window. The bench holds the answer back for exactly TIMEOUT_CYCLES-1 cycles after the request rises and then checks that a response-received status appears with no timeout bit. The second is a software status clear written on the very edge that a completion sets a bit. The bench drives the clear write and the answer strobe in the same cycle, then expects the newly set bit to survive while an older sticky bit named in the same write is gone.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/100ps
package sdcmd_pkg;

    localparam int DW              = 32;
    localparam int REG_AW          = 3;
    localparam int IDX_W           = 6;
    localparam int LEN_W           = 5;
    localparam int RSP_BYTES       = 16;
    localparam int RSP_SHORT_BYTES = 4;
    localparam int RSP_W           = RSP_BYTES * 8;
    localparam int RSP_WORDS       = RSP_W / DW;
    localparam int CMD_W           = 11;

    localparam logic [REG_AW-1:0] A_ARG  = 3'd0;
    localparam logic [REG_AW-1:0] A_CMD  = 3'd1;
    localparam logic [REG_AW-1:0] A_STAT = 3'd2;
    localparam logic [REG_AW-1:0] A_CLR  = 3'd3;

    localparam int SB_TIMEOUT = 2;
    localparam int SB_RESPEND = 6;
    localparam int SB_SENT    = 7;
    localparam int SB_ACTIVE  = 11;

    // Packed so that the fields land on command bits 10..0.
    typedef struct packed {
        logic             start;
        logic             pend_mode;
        logic             irq_mode;
        logic             long_rsp;
        logic             expect_rsp;
        logic [IDX_W-1:0] index;
    } cmd_t;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             expect_rsp;
        logic             long_rsp;
    } issue_t;

    typedef enum logic [1:0] {
        OUT_SENT,
        OUT_SHORT,
        OUT_LONG,
        OUT_TIMEOUT
    } outcome_e;

    typedef enum logic {
        S_IDLE,
        S_WAIT
    } seq_state_e;

    function automatic outcome_e classify(input issue_t c, input logic err,
                                          input logic [LEN_W-1:0] len);
        if (err)
            return OUT_TIMEOUT;
        if (!c.expect_rsp)
            return OUT_SENT;
        if (len == LEN_W'(RSP_SHORT_BYTES))
            return c.long_rsp ? OUT_TIMEOUT : OUT_SHORT;
        if (len == LEN_W'(RSP_BYTES))
            return OUT_LONG;
        return OUT_TIMEOUT;
    endfunction

    function automatic logic [DW-1:0] word_of(input logic [RSP_W-1:0] d, input int k);
        return d[RSP_W-1-DW*k -: DW];
    endfunction

endpackage

// File: rtl/sdcmd_seq.sv
`timescale 1ns/100ps
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_i,
    input  issue_t           issue_info_i,
    input  logic [DW-1:0]    arg_i,
    input  logic             rsp_valid_i,
    input  logic             rsp_err_i,
    input  logic [LEN_W-1:0] rsp_len_i,
    output logic             req_valid_o,
    output logic [IDX_W-1:0] req_index_o,
    output logic [DW-1:0]    req_arg_o,
    output logic             active_o,
    output logic             done_o,
    output outcome_e         outcome_o,
    output logic             kick_o
);

    localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    issue_t           info_q;
    logic [DW-1:0]    arg_q;
    logic             kick_q;
    logic             expiring;

    assign expiring    = (cnt_q == CNT_LAST);
    assign done_o      = (state_q == S_WAIT) && (rsp_valid_i || expiring);
    assign outcome_o   = rsp_valid_i ? classify(info_q, rsp_err_i, rsp_len_i) : OUT_TIMEOUT;
    assign req_valid_o = (state_q == S_WAIT);
    assign active_o    = (state_q == S_WAIT);
    assign req_index_o = info_q.index;
    assign req_arg_o   = arg_q;
    assign kick_o      = kick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            info_q  <= '0;
            arg_q   <= '0;
            kick_q  <= 1'b0;
        end else begin
            kick_q <= done_o;
            case (state_q)
                S_IDLE: begin
                    if (issue_i) begin
                        state_q <= S_WAIT;
                        cnt_q   <= '0;
                        info_q  <= issue_info_i;
                        arg_q   <= arg_i;
                    end
                end
                S_WAIT: begin
                    if (done_o)
                        state_q <= S_IDLE;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    AST_ISSUE_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> req_valid_o); // R2

    AST_DONE_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !req_valid_o); // R7

    AST_KICK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> kick_o); // R12

    AST_KICK_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        kick_o |-> $past(done_o)); // R14

endmodule

// File: rtl/sdcmd_resp.sv
`timescale 1ns/100ps
module sdcmd_resp
    import sdcmd_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           done_i,
    input  outcome_e                       outcome_i,
    input  logic [RSP_W-1:0]               rsp_data_i,
    output logic [RSP_WORDS-1:0][DW-1:0]   words_o
);

    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
        localparam bit IS_FIRST = (k == 0);
        localparam bit IS_LAST  = (k == RSP_WORDS - 1);
        logic [DW-1:0] w_q;
        logic [DW-1:0] long_val;

        assign long_val = IS_LAST ? (word_of(rsp_data_i, k) & ~DW'(1)) : word_of(rsp_data_i, k);

        always_ff @(posedge clk) begin
            if (rst) begin
                w_q <= '0;
            end else if (done_i) begin
                if (outcome_i == OUT_SHORT)
                    w_q <= IS_FIRST ? word_of(rsp_data_i, k) : '0;
                else if (outcome_i == OUT_LONG)
                    w_q <= long_val;
            end
        end

        assign words_o[k] = w_q;
    end

    AST_LONG_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_i && outcome_i == OUT_LONG) |=> !words_o[RSP_WORDS-1][0]); // R6

    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_i && outcome_i == OUT_SHORT) |=> (words_o[RSP_WORDS-1:1] == '0)); // R5

    AST_WORDS_HOLD_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (done_i && outcome_i == OUT_TIMEOUT) |=> $stable(words_o)); // R4

endmodule

// File: rtl/sdcmd_regs.sv
`timescale 1ns/100ps
module sdcmd_regs
    import sdcmd_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [REG_AW-1:0]             wr_addr,
    input  logic [DW-1:0]                 wr_data,
    input  logic [REG_AW-1:0]             rd_addr,
    output logic [DW-1:0]                 rd_data,
    input  logic                          active_i,
    input  logic                          done_i,
    input  outcome_e                      outcome_i,
    input  logic [RSP_WORDS-1:0][DW-1:0]  words_i,
    output logic                          issue_o,
    output issue_t                        issue_info_o,
    output logic [DW-1:0]                 arg_o
);

    logic [DW-1:0] arg_q;
    cmd_t          cmd_q;
    cmd_t          wr_cmd;
    logic          cmd_wr;
    logic          clr_wr;
    logic          st_to_q, st_re_q, st_sent_q;
    logic          set_to, set_re, set_sent;
    logic [DW-1:0] status_w;

    assign cmd_wr = wr_en && (wr_addr == A_CMD);
    assign clr_wr = wr_en && (wr_addr == A_CLR);
    assign wr_cmd = cmd_t'(wr_data[CMD_W-1:0]);

    assign issue_o = cmd_wr && !active_i && wr_cmd.start && !wr_cmd.irq_mode && !wr_cmd.pend_mode;
    assign issue_info_o = '{index: wr_cmd.index, expect_rsp: wr_cmd.expect_rsp,
                            long_rsp: wr_cmd.long_rsp};
    assign arg_o = arg_q;

    assign set_to   = done_i && (outcome_i == OUT_TIMEOUT);
    assign set_re   = done_i && (outcome_i == OUT_SHORT || outcome_i == OUT_LONG);
    assign set_sent = done_i && (outcome_i == OUT_SENT);

    always_ff @(posedge clk) begin
        if (rst) begin
            arg_q     <= '0;
            cmd_q     <= '0;
            st_to_q   <= 1'b0;
            st_re_q   <= 1'b0;
            st_sent_q <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == A_ARG))
                arg_q <= wr_data;

            if (cmd_wr && !active_i) begin
                cmd_q       <= wr_cmd;
                cmd_q.start <= issue_o;
            end else if (done_i) begin
                cmd_q.start <= 1'b0;
            end

            st_to_q   <= (st_to_q   && !(clr_wr && wr_data[SB_TIMEOUT])) || set_to;
            st_re_q   <= (st_re_q   && !(clr_wr && wr_data[SB_RESPEND])) || set_re;
            st_sent_q <= (st_sent_q && !(clr_wr && wr_data[SB_SENT]))    || set_sent;
        end
    end

    always_comb begin
        status_w             = '0;
        status_w[SB_TIMEOUT] = st_to_q;
        status_w[SB_RESPEND] = st_re_q;
        status_w[SB_SENT]    = st_sent_q;
        status_w[SB_ACTIVE]  = active_i;
    end

    always_comb begin
        if (rd_addr[REG_AW-1])
            rd_data = words_i[rd_addr[REG_AW-2:0]];
        else begin
            case (rd_addr)
                A_ARG:   rd_data = arg_q;
                A_CMD:   rd_data = DW'(cmd_q);
                A_STAT:  rd_data = status_w;
                default: rd_data = '0;
            endcase
        end
    end

    AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (active_i && !done_i) |=> $stable(cmd_q)); // R10

    AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !cmd_q.start); // R7

    AST_DONE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        done_i |-> active_i); // R14

    AST_MODE_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !active_i && (wr_cmd.irq_mode || wr_cmd.pend_mode)) |=> !cmd_q.start); // R11

endmodule

// File: rtl/sdcmd_unit.sv
`timescale 1ns/100ps
module sdcmd_unit
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [31:0]  wr_data,
    input  logic [2:0]   rd_addr,
    output logic [31:0]  rd_data,
    output logic         card_req_valid,
    output logic [5:0]   card_req_index,
    output logic [31:0]  card_req_arg,
    input  logic         card_rsp_valid,
    input  logic         card_rsp_err,
    input  logic [4:0]   card_rsp_len,
    input  logic [127:0] card_rsp_data,
    output logic         data_kick
);

    logic                         issue;
    issue_t                       issue_info;
    logic [DW-1:0]                arg;
    logic                         active;
    logic                         done;
    outcome_e                     outcome;
    logic [RSP_WORDS-1:0][DW-1:0] words;

    sdcmd_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .active_i     (active),
        .done_i       (done),
        .outcome_i    (outcome),
        .words_i      (words),
        .issue_o      (issue),
        .issue_info_o (issue_info),
        .arg_o        (arg)
    );

    sdcmd_seq #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .issue_i      (issue),
        .issue_info_i (issue_info),
        .arg_i        (arg),
        .rsp_valid_i  (card_rsp_valid),
        .rsp_err_i    (card_rsp_err),
        .rsp_len_i    (card_rsp_len),
        .req_valid_o  (card_req_valid),
        .req_index_o  (card_req_index),
        .req_arg_o    (card_req_arg),
        .active_o     (active),
        .done_o       (done),
        .outcome_o    (outcome),
        .kick_o       (data_kick)
    );

    sdcmd_resp u_resp (
        .clk        (clk),
        .rst        (rst),
        .done_i     (done),
        .outcome_i  (outcome),
        .rsp_data_i (card_rsp_data),
        .words_o    (words)
    );

endmodule

// File: tb/sim_sdcmd_unit.sv
`timescale 1ns/100ps
module sim_sdcmd_unit;

    localparam int T = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         card_req_valid;
    logic [5:0]   card_req_index;
    logic [31:0]  card_req_arg;
    logic         card_rsp_valid = 1'b0;
    logic         card_rsp_err = 1'b0;
    logic [4:0]   card_rsp_len = '0;
    logic [127:0] card_rsp_data = '0;
    logic         data_kick;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    logic [31:0] mw [4];

    sdcmd_unit #(.TIMEOUT_CYCLES(T)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .card_req_valid(card_req_valid),
        .card_req_index(card_req_index), .card_req_arg(card_req_arg),
        .card_rsp_valid(card_rsp_valid), .card_rsp_err(card_rsp_err),
        .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data), .data_kick(data_kick)
    );

    always #2.5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic chk_words(input string tag);
        for (int k = 0; k < 4; k++) chk_reg(tag, 3'(4 + k), mw[k]);
    endtask

    function automatic logic [127:0] mk_data(input int seed);
        logic [127:0] d;
        for (int i = 0; i < 16; i++) d[127-8*i -: 8] = 8'((seed * 13 + i * 29 + 1) & 255);
        return d;
    endfunction

    task automatic answer(input logic err, input logic [4:0] len, input logic [127:0] d);
        card_rsp_valid = 1'b1; card_rsp_err = err; card_rsp_len = len; card_rsp_data = d;
        tick();
        card_rsp_valid = 1'b0; card_rsp_err = 1'b0;
    endtask

    function automatic logic [31:0] cmdw(input bit st, input bit irq, input bit pend,
                                         input bit lng, input bit exr, input logic [5:0] idx);
        return {21'd0, st, pend, irq, lng, exr, idx};
    endfunction

    initial begin
        #750000;
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 4; k++) mw[k] = '0;
        repeat (3) tick();
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 8; a++) chk_reg("R1 reg", 3'(a), 32'h0);
        chk("R1 req_valid", 32'(card_req_valid), 0);
        chk("R1 kick", 32'(data_kick), 0);

        // Sweep: expect x long x err x every length
        for (int it = 0; it < 256; it++) begin
            bit exr, lng, er;
            logic [4:0] len;
            logic [5:0] idx;
            logic [31:0] argv, st_exp;
            logic [127:0] d;
            string tag;
            exr = it[7]; lng = it[6]; er = it[5]; len = 5'(it & 31);
            idx = 6'((it * 7) & 63);
            argv = 32'h1000_0000 + 32'(it) * 32'h0101_0103;
            d = mk_data(it);
            wr(3'd3, 32'hFFFF_FFFF);
            wr(3'd0, argv);
            wr(3'd1, cmdw(1, 0, 0, lng, exr, idx));
            chk("R2 req_valid", 32'(card_req_valid), 1);
            chk("R2 index", 32'(card_req_index), 32'(idx));
            chk("R2 arg", card_req_arg, argv);
            chk_reg("R2 active", 3'd2, 32'h800);
            chk_reg("R2 start reads 1", 3'd1, cmdw(1, 0, 0, lng, exr, idx));
            answer(er, len, d);
            if (er) begin
                tag = "R9"; st_exp = 32'h4;
            end else if (!exr) begin
                tag = "R3"; st_exp = 32'h80;
            end else if (len == 5'd4 && !lng) begin
                tag = "R5"; st_exp = 32'h40;
                mw[0] = d[127:96]; mw[1] = 0; mw[2] = 0; mw[3] = 0;
            end else if (len == 5'd16) begin
                tag = "R6"; st_exp = 32'h40;
                for (int k = 0; k < 4; k++) mw[k] = d[127-32*k -: 32];
                mw[3][0] = 1'b0;
            end else begin
                tag = "R4"; st_exp = 32'h4;
            end
            chk_reg(tag, 3'd2, st_exp);
            chk_words(tag);
            chk_reg("R7 start cleared", 3'd1, cmdw(0, 0, 0, lng, exr, idx));
            chk("R7 req dropped", 32'(card_req_valid), 0);
            chk("R12 kick high", 32'(data_kick), 1);
            tick();
            chk("R12 kick one cycle", 32'(data_kick), 0);
        end

        // R8: no answer -> timeout after exactly T cycles
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd1, cmdw(1, 0, 0, 0, 1, 6'd3));
        repeat (T - 1) tick();
        chk("R8 still active", 32'(card_req_valid), 1);
        chk_reg("R8 active bit", 3'd2, 32'h800);
        tick();
        chk("R8 req dropped", 32'(card_req_valid), 0);
        chk_reg("R8 timeout bit", 3'd2, 32'h4);
        chk_words("R8 words kept");
        chk("R8 kick", 32'(data_kick), 1);
        tick();

        // R8: answer in the last cycle of the window wins
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd1, cmdw(1, 0, 0, 0, 1, 6'd4));
        repeat (T - 1) tick();
        answer(0, 5'd4, mk_data(900));
        mw[0] = mk_data(900)[127:96]; mw[1] = 0; mw[2] = 0; mw[3] = 0;
        chk_reg("R8 last-cycle answer", 3'd2, 32'h40);
        chk_words("R8 last-cycle words");
        tick();

        // R10: command write while outstanding is ignored
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd1, cmdw(1, 0, 0, 0, 0, 6'd5));
        wr(3'd1, cmdw(1, 0, 0, 1, 1, 6'd33));
        chk_reg("R10 cmd kept", 3'd1, cmdw(1, 0, 0, 0, 0, 6'd5));
        chk("R10 index kept", 32'(card_req_index), 32'd5);
        answer(0, 5'd16, mk_data(901));
        chk_reg("R10 completes as no-response", 3'd2, 32'h80);
        chk_words("R10 words kept");
        tick();

        // R14: stray answer while idle
        answer(0, 5'd16, mk_data(902));
        chk_reg("R14 status", 3'd2, 32'h80);
        chk_words("R14 words");
        chk("R14 no kick", 32'(data_kick), 0);
        tick();
        chk("R14 no kick later", 32'(data_kick), 0);

        // R13: clear and completion on the same edge
        wr(3'd1, cmdw(1, 0, 0, 0, 1, 6'd6));
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'hFFFF_FFFF;
        answer(0, 5'd4, mk_data(903));
        wr_en = 1'b0;
        mw[0] = mk_data(903)[127:96]; mw[1] = 0; mw[2] = 0; mw[3] = 0;
        chk_reg("R13 set wins, old cleared", 3'd2, 32'h40);
        wr(3'd3, 32'h0000_0084);
        chk_reg("R13 unselected kept", 3'd2, 32'h40);
        wr(3'd3, 32'h0000_0040);
        chk_reg("R13 selected cleared", 3'd2, 32'h0);

        // R11: mode bits block the issue
        wr(3'd1, cmdw(1, 1, 0, 0, 1, 6'd9));
        chk_reg("R11 irq stored without start", 3'd1, cmdw(0, 1, 0, 0, 1, 6'd9));
        chk("R11 no request", 32'(card_req_valid), 0);
        wr(3'd1, cmdw(1, 0, 1, 1, 1, 6'd10));
        chk_reg("R11 pend stored without start", 3'd1, cmdw(0, 0, 1, 1, 1, 6'd10));
        chk("R11 no request pend", 32'(card_req_valid), 0);
        chk_reg("R11 status", 3'd2, 32'h0);
        chk("R11 no kick", 32'(data_kick), 0);
        chk_words("R11 words");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule